// File: doc/BRIEF.md
# Dual-Mode Byte Host Register Port

This block is the device side of an 8-bit asynchronous host bus. Chip select, a 3-bit address, a byte of write data and two strobes arrive from the host without any timing relation to the system clock. The block passes them through flop synchronizers and treats the falling edge of chip select as the start of one access. It then decodes the access against eight host-visible registers. A mode input selects one of two strobe conventions. In the first, read and write each have their own strobe. In the second, one strobe carries the direction and the read strobe is ignored.

One register address is a byte port into a code FIFO. Bytes written there are gathered most significant byte first, and every fourth byte pushes one 32-bit word downstream. The host is paced by an active-low wait and is signalled by an interrupt. Both are given as open-drain style enables: one enable pulls the pad low, and a second enable drives it high for one cycle just before it is released. While the downstream FIFO reports full, a byte write to the FIFO port is held with wait asserted until space appears.

Top module: `hostbus_regif`

## Requirements
- R1: Register map by address: 0 is the code byte port (write only, reads return 0); 1 is status (read only, writes ignored); 2 is the interrupt mask (read/write); 3 returns the number of code bytes collected so far in bits 1:0; 4 to 7 are configuration bytes, read/write, and address 4+k drives `cfg_out[8k+7:8k]`. All registers reset to 0.
- R2: An access is started only by a falling edge of `hb_cs_n` after synchronization. Address, data and strobes are sampled at that edge, and while chip select stays high nothing is accessed.
- R3: With `mode_sep`=1, `hb_rd_n` low with `hb_rw_n` high is a read, and `hb_rw_n` low with `hb_rd_n` high is a write. Both high or both low makes the cycle a no-op that changes no register.
- R4: With `mode_sep`=0, `hb_rw_n` low is a write and `hb_rw_n` high is a read. The level of `hb_rd_n` has no effect.
- R5: Code bytes B0..B3 written in that order produce `fifo_wdata` = {B0,B1,B2,B3} with a single-cycle `fifo_push` on the fourth byte only. The byte count then returns to 0.
- R6: `wait_low_en` rises only after chip select falls and drops when the access completes. `wait_high_en` is then high for exactly one cycle, and never together with `wait_low_en`.
- R7: A write to the code byte port while `fifo_full`=1 keeps `wait_low_en` asserted and does not take the byte. The byte is taken once `fifo_full` drops, and `fifo_push` never fires while `fifo_full` was high in the previous cycle.
- R8: `hb_data_oe` is high only for read accesses, from completion until chip select is seen high again. `hb_data_out` then holds the register value.
- R9: A pulse on `evt_set[i]` sets status bit i. A status read returns the bits and clears them, except that bits set in the same cycle as the clear are kept.
- R10: `irq_low_en` is high while any status bit with a set mask bit is 1. When it drops, `irq_high_en` is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_sep | input | 1 | 1: separate read and write strobes; 0: single direction strobe |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_addr | input | 3 | Host register address |
| hb_data_in | input | 8 | Host write data (input side of the data pads) |
| hb_data_out | output | 8 | Read data toward the data pads |
| hb_data_oe | output | 1 | Drive enable for the data pads |
| hb_rd_n | input | 1 | Read strobe (separate mode only) |
| hb_rw_n | input | 1 | Write strobe, or direction strobe in single mode |
| wait_low_en | output | 1 | Pull the wait pad low |
| wait_high_en | output | 1 | Drive the wait pad high for one cycle before release |
| irq_low_en | output | 1 | Pull the interrupt pad low |
| irq_high_en | output | 1 | Drive the interrupt pad high for one cycle before release |
| evt_set | input | 8 | Status event pulses from the core |
| fifo_full | input | 1 | Downstream code FIFO cannot accept a word |
| fifo_push | output | 1 | One-cycle push of a completed word |
| fifo_wdata | output | 32 | Packed code word |
| cfg_out | output | 32 | Four configuration bytes |

## Verification
Two distinct byte sequences are sent through the code port, and the scoreboard compares each pushed word against the order the bytes were written. A byte-order swap or a push on the wrong byte therefore shows as a mismatch. The same register reads and writes are repeated in both strobe modes, with the ignored read strobe held at the wrong level in single mode, and with no-op strobe combinations in separate mode. This tells correct direction decoding apart from a decoder that honours the wrong pin. A FIFO-full stall checks that wait is held and the byte is not lost. Masked and unmasked events followed by a status read separate interrupt masking from read-to-clear.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_dir_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EXEC = 2'd1,
    S_HOLD = 2'd2
  } hb_state_t;

  localparam logic [2:0] A_CODE = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_MASK = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;

  // Strobe convention decode: separate mode needs exactly one strobe low.
  function automatic acc_dir_t decode_dir(input logic sep, input logic rd_n,
                                          input logic rw_n);
    acc_dir_t d;
    if (sep) begin
      if (!rd_n && rw_n)      d = ACC_RD;
      else if (rd_n && !rw_n) d = ACC_WR;
      else                    d = ACC_NONE;
    end else begin
      d = rw_n ? ACC_RD : ACC_WR;
    end
    return d;
  endfunction

  function automatic logic is_cfg_addr(input logic [2:0] a);
    return a[2];
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hb_packer.sv
module hb_packer #(
  parameter int DW = 8,
  parameter int WORD_BYTES = 4,
  localparam int WW = DW * WORD_BYTES,
  localparam int AW = DW * (WORD_BYTES - 1),
  localparam int CW = $clog2(WORD_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_in,
  output logic          word_push,
  output logic [WW-1:0] word_out,
  output logic [CW-1:0] byte_cnt
);
  localparam logic [CW-1:0] LAST = CW'(WORD_BYTES - 1);

  logic [AW-1:0] acc_q;

  // Earlier bytes sit in the upper lanes: first byte written ends up MSB.
  function automatic logic [WW-1:0] join_word(input logic [AW-1:0] acc,
                                              input logic [DW-1:0] b);
    return {acc, b};
  endfunction

  function automatic logic [AW-1:0] shift_in(input logic [AW-1:0] acc,
                                             input logic [DW-1:0] b);
    logic [WW-1:0] t;
    t = {acc, b};
    return t[AW-1:0];
  endfunction

  wire last_byte = byte_valid && (byte_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      byte_cnt  <= '0;
      word_push <= 1'b0;
      word_out  <= '0;
    end else begin
      word_push <= last_byte;
      if (last_byte) begin
        word_out <= join_word(acc_q, byte_in);
        acc_q    <= '0;
        byte_cnt <= '0;
      end else if (byte_valid) begin
        acc_q    <= shift_in(acc_q, byte_in);
        byte_cnt <= byte_cnt + 1'b1;
      end
    end
  end

  // R5: a push follows only the last byte, leaving the count at zero
  p_push_resets_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> byte_cnt == '0);

  // R5: each earlier byte advances the count by one
  p_count_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_cnt != LAST) |=> byte_cnt == $past(byte_cnt) + 1'b1);
endmodule

// File: rtl/hb_odrain.sv
module hb_odrain (
  input  logic clk,
  input  logic rst_n,
  input  logic low_req,
  output logic low_en,
  output logic high_en
);
  logic prev_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_low <= 1'b0;
    else        prev_low <= low_req;
  end

  assign low_en  = low_req;
  assign high_en = prev_low && !low_req;
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif
  import hostbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int WORD_BYTES = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WW = DW * WORD_BYTES,
  localparam int NCFG = 4,
  localparam int CW = $clog2(WORD_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sep,
  input  logic          hb_cs_n,
  input  logic [2:0]    hb_addr,
  input  logic [DW-1:0] hb_data_in,
  output logic [DW-1:0] hb_data_out,
  output logic          hb_data_oe,
  input  logic          hb_rd_n,
  input  logic          hb_rw_n,
  output logic          wait_low_en,
  output logic          wait_high_en,
  output logic          irq_low_en,
  output logic          irq_high_en,
  input  logic [DW-1:0] evt_set,
  input  logic          fifo_full,
  output logic          fifo_push,
  output logic [WW-1:0] fifo_wdata,
  output logic [NCFG*DW-1:0] cfg_out
);
  // ---------------- synchronizers
  logic [2:0] ctl_s;
  logic [DW+3:0] dat_s;

  hb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({hb_cs_n, hb_rd_n, hb_rw_n}), .q(ctl_s));

  hb_sync #(.W(DW+4), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d({mode_sep, hb_addr, hb_data_in}), .q(dat_s));

  wire          cs_s   = ctl_s[2];
  wire          rd_n_s = ctl_s[1];
  wire          rw_n_s = ctl_s[0];
  wire          sep_s  = dat_s[DW+3];
  wire [2:0]    addr_s = dat_s[DW+2:DW];
  wire [DW-1:0] data_s = dat_s[DW-1:0];

  // ---------------- access start
  logic cs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_s;
  end

  hb_state_t state;
  acc_dir_t  dir_now, acc_dir;
  logic [2:0]    acc_addr;
  logic [DW-1:0] acc_data;

  wire cs_fall = cs_q && !cs_s;
  assign dir_now = decode_dir(sep_s, rd_n_s, rw_n_s);
  wire acc_start = (state == S_IDLE) && cs_fall && (dir_now != ACC_NONE);

  wire code_blocked = (state == S_EXEC) && (acc_dir == ACC_WR) &&
                      (acc_addr == A_CODE) && fifo_full;
  wire exec_fire = (state == S_EXEC) && !code_blocked;
  wire do_wr     = exec_fire && (acc_dir == ACC_WR);
  wire do_rd     = exec_fire && (acc_dir == ACC_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      acc_dir  <= ACC_NONE;
      acc_addr <= '0;
      acc_data <= '0;
    end else begin
      case (state)
        S_IDLE: if (acc_start) begin
          state    <= S_EXEC;
          acc_dir  <= dir_now;
          acc_addr <= addr_s;
          acc_data <= data_s;
        end
        S_EXEC: if (exec_fire) state <= S_HOLD;
        S_HOLD: if (cs_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- registers
  logic [DW-1:0] status_q, mask_q;
  logic [DW-1:0] cfg_q [NCFG];
  logic [CW-1:0] byte_cnt;

  wire status_clr = do_rd && (acc_addr == A_STAT);
  wire mask_wr    = do_wr && (acc_addr == A_MASK);
  wire code_wr    = do_wr && (acc_addr == A_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_clr ? '0 : status_q) | evt_set;
      if (mask_wr) mask_q <= acc_data;
    end
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[g] <= '0;
      else if (do_wr && is_cfg_addr(acc_addr) && acc_addr[1:0] == 2'(g))
        cfg_q[g] <= acc_data;
    end
    assign cfg_out[g*DW +: DW] = cfg_q[g];
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (is_cfg_addr(acc_addr)) rd_mux = cfg_q[acc_addr[1:0]];
    else begin
      case (acc_addr)
        A_STAT:  rd_mux = status_q;
        A_MASK:  rd_mux = mask_q;
        A_CNT:   rd_mux = DW'(byte_cnt);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hb_data_out <= '0;
    else if (do_rd) hb_data_out <= rd_mux;
  end

  assign hb_data_oe = (state == S_HOLD) && (acc_dir == ACC_RD);

  // ---------------- code word packer
  hb_packer #(.DW(DW), .WORD_BYTES(WORD_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .byte_valid(code_wr), .byte_in(acc_data),
    .word_push(fifo_push), .word_out(fifo_wdata), .byte_cnt(byte_cnt));

  // ---------------- open-drain style outputs
  wire irq_req = |(status_q & mask_q);

  hb_odrain u_wait (.clk(clk), .rst_n(rst_n), .low_req(state == S_EXEC),
                    .low_en(wait_low_en), .high_en(wait_high_en));
  hb_odrain u_irq  (.clk(clk), .rst_n(rst_n), .low_req(irq_req),
                    .low_en(irq_low_en), .high_en(irq_high_en));

  // ---------------- assertions
  // R6: a started access holds wait low in the next cycle
  p_wait_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> wait_low_en);

  // R6: the release pulse belongs to a completed access
  p_wait_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_high_en |-> state == S_HOLD);

  // R2: the machine leaves idle only on a synchronized select fall
  p_start_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !cs_fall) |=> state == S_IDLE);

  // R7: no word goes out while the FIFO was full
  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !$past(fifo_full));

  // R8: data drive begins right after an executed read
  p_oe_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_data_oe) |-> $past(state == S_EXEC && acc_dir == ACC_RD));

  // R9: a clearing read with no new events empties status
  p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && evt_set == '0) |=> status_q == '0);

  // R10: the interrupt releases only after a status clear or mask write
  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_low_en) |-> $past(status_clr || mask_wr));
endmodule

// File: tb/hostbus_regif_test.sv
module hostbus_regif_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic mode_sep = 1, hb_cs_n = 1, hb_rd_n = 1, hb_rw_n = 1;
  logic [2:0] hb_addr = 0;
  logic [7:0] hb_data_in = 0, evt_set = 0;
  logic fifo_full = 0;
  logic [7:0] hb_data_out;
  logic hb_data_oe, wait_low_en, wait_high_en, irq_low_en, irq_high_en, fifo_push;
  logic [31:0] fifo_wdata, cfg_out;

  always #(CLK_NS/2) clk = ~clk;

  hostbus_regif uut (
    .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .hb_cs_n(hb_cs_n),
    .hb_addr(hb_addr), .hb_data_in(hb_data_in), .hb_data_out(hb_data_out),
    .hb_data_oe(hb_data_oe), .hb_rd_n(hb_rd_n), .hb_rw_n(hb_rw_n),
    .wait_low_en(wait_low_en), .wait_high_en(wait_high_en),
    .irq_low_en(irq_low_en), .irq_high_en(irq_high_en), .evt_set(evt_set),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .cfg_out(cfg_out));

  int n_checks = 0, n_fail = 0;
  int wait_pulses = 0, irq_pulses = 0, overlap = 0;
  logic [31:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: counts release pulses and scores pushed words
  always @(negedge clk) begin
    if (rst_n) begin
      if (wait_high_en) wait_pulses++;
      if (irq_high_en) irq_pulses++;
      if (wait_high_en && wait_low_en) overlap++;
      if (fifo_push) begin
        if (exp_q.size() == 0) chk("R5 unexpected push", fifo_wdata, 32'hx);
        else chk("R5 packed word", fifo_wdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_cycle(input logic [2:0] a, input logic [7:0] d,
                           input logic rdn, input logic rwn,
                           output logic [7:0] q, output logic oe, output logic seen);
    @(negedge clk);
    hb_addr = a; hb_data_in = d; hb_rd_n = rdn; hb_rw_n = rwn;
    repeat (3) @(negedge clk);
    hb_cs_n = 0;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (wait_low_en) begin seen = 1; break; end
    end
    if (seen) begin
      for (int g = 0; g < 5000 && wait_low_en; g++) @(negedge clk);
    end
    q = hb_data_out; oe = hb_data_oe;
    @(negedge clk); hb_cs_n = 1;
    repeat (4) @(negedge clk);
    hb_rd_n = 1; hb_rw_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q; logic oe, s;
    bus_cycle(a, d, 1'b1, 1'b0, q, oe, s);
    chk("R8 no drive on write", {31'b0, oe}, 0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] q);
    logic oe, s;
    bus_cycle(a, 8'h00, mode_sep ? 1'b0 : 1'b1, 1'b1, q, oe, s);
    chk("R8 drive on read", {31'b0, oe}, 1);
  endtask

  task automatic code_byte(input logic [7:0] b);
    wr(3'd0, b);
  endtask

  logic [7:0] rv;
  logic oe_v, seen_v;
  int wp0, ip0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // reset state
    chk("R1 cfg reset", cfg_out, 0);
    chk("R6 wait idle", {30'b0, wait_low_en, wait_high_en}, 0);
    chk("R10 irq idle", {31'b0, irq_low_en}, 0);
    chk("R8 oe idle", {31'b0, hb_data_oe}, 0);

    // R2: strobes and address set, chip select kept high
    hb_addr = 3'd4; hb_data_in = 8'hEE; hb_rw_n = 0;
    repeat (10) @(negedge clk);
    chk("R2 no access without select", {31'b0, wait_low_en}, 0);
    hb_rw_n = 1;
    repeat (3) @(negedge clk);
    chk("R2 cfg untouched", cfg_out, 0);

    // R1 / R3 register access, separate-strobe mode
    mode_sep = 1;
    repeat (4) @(negedge clk);
    wp0 = wait_pulses;
    wr(3'd4, 8'h12); wr(3'd5, 8'h34); wr(3'd6, 8'h56); wr(3'd7, 8'h78);
    chk("R1 cfg byte lanes", cfg_out, 32'h78563412);
    chk("R6 one release pulse per access", wait_pulses - wp0, 4);
    rd(3'd6, rv); chk("R3 sep-mode read", rv, 8'h56);
    wr(3'd1, 8'hFF); rd(3'd1, rv); chk("R1 status write ignored", rv, 0);
    rd(3'd0, rv); chk("R1 code port reads zero", rv, 0);
    // R3 no-op: both strobes low, then both high
    bus_cycle(3'd4, 8'hAA, 1'b0, 1'b0, rv, oe_v, seen_v);
    chk("R3 both low no wait", {31'b0, seen_v}, 0);
    bus_cycle(3'd4, 8'hBB, 1'b1, 1'b1, rv, oe_v, seen_v);
    chk("R3 both high no wait", {31'b0, seen_v}, 0);
    chk("R3 no-op leaves cfg", cfg_out, 32'h78563412);

    // R5 packing, first sequence, with count readback
    exp_q.push_back(32'h11223344);
    code_byte(8'h11); code_byte(8'h22);
    rd(3'd3, rv); chk("R5 byte count two", rv, 2);
    code_byte(8'h33); code_byte(8'h44);
    rd(3'd3, rv); chk("R5 byte count wrapped", rv, 0);

    // R4 single-strobe mode, rd_n held low must be ignored
    mode_sep = 0;
    repeat (4) @(negedge clk);
    bus_cycle(3'd5, 8'hC7, 1'b0, 1'b0, rv, oe_v, seen_v);
    chk("R4 write with rd_n low", cfg_out[15:8], 8'hC7);
    bus_cycle(3'd5, 8'h00, 1'b0, 1'b1, rv, oe_v, seen_v);
    chk("R4 read with rd_n low", rv, 8'hC7);
    chk("R4 read drives bus", {31'b0, oe_v}, 1);
    @(negedge clk);
    chk("R8 drive ends after select rises", {31'b0, hb_data_oe}, 0);

    // R5 second sequence plus R7 stall on the last byte
    exp_q.push_back(32'hA55AC33C);
    code_byte(8'hA5); code_byte(8'h5A); code_byte(8'hC3);
    fifo_full = 1;
    fork
      bus_cycle(3'd0, 8'h3C, 1'b1, 1'b0, rv, oe_v, seen_v);
      begin
        repeat (30) @(negedge clk);
        chk("R7 wait held while full", {31'b0, wait_low_en}, 1);
        chk("R7 byte not taken while full", exp_q.size(), 1);
        fifo_full = 0;
      end
    join
    chk("R7 word delivered after full drops", exp_q.size(), 0);
    chk("R6 never high and low together", overlap, 0);

    // R9 / R10 status and interrupt
    mode_sep = 1;
    repeat (4) @(negedge clk);
    wr(3'd2, 8'h05);
    evt_set = 8'h02; @(negedge clk); evt_set = 0;
    repeat (2) @(negedge clk);
    chk("R10 masked event no irq", {31'b0, irq_low_en}, 0);
    evt_set = 8'h04; @(negedge clk); evt_set = 0;
    repeat (2) @(negedge clk);
    chk("R10 unmasked event irq", {31'b0, irq_low_en}, 1);
    ip0 = irq_pulses;
    rd(3'd1, rv); chk("R9 status value", rv, 8'h06);
    chk("R10 irq released", {31'b0, irq_low_en}, 0);
    chk("R10 one high pulse", irq_pulses - ip0, 1);
    rd(3'd1, rv); chk("R9 status cleared", rv, 0);

    if (exp_q.size() != 0) chk("R5 words outstanding", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule